// File: doc/BRIEF.md
# Corrected Error Threshold Interrupt Bank

This block belongs to one error-reporting bank. It holds a 32-bit control word that software reads and writes through a simple register port, and it counts hardware-corrected errors that arrive as single-cycle strobes. When signalling is enabled and the count reaches the threshold held in the control word, the block sends a one-cycle interrupt request to the local interrupt controller. It then restarts the count.

Two build-time switches decide whether the threshold field and the signalling enable exist. Software finds out which features a bank has by writing them and reading them back. A field that the bank does not implement always reads as zero. A bank without signalling never raises a request. Signalling depends only on this bank's control word. No global enable and no other register of the bank gates it.

Top module: `cet_bank`

## Requirements
- R1: The threshold field is bits 14:0 of the control word. With `HAS_THRESH`=1 a write stores it and readback returns it. With `HAS_THRESH`=0 these bits always read 0. The word changes only on a write.
- R2: Bit 30 of the control word is the signalling enable. With `HAS_SIGNAL`=1 a written 1 reads back as 1. With `HAS_SIGNAL`=0 it always reads 0.
- R3: Every bit other than 14:0 and 30 always reads 0, whatever value was written.
- R4: While enable is 1, every strobe on `err_strobe` adds one to a counter. The strobe that brings the counter to the effective threshold makes `irq_pulse` high for exactly the next cycle, and it clears the counter.
- R5: A threshold of 0 acts as a threshold of 1: every accepted strobe raises the request.
- R6: A register write clears the counter. A strobe in the same cycle as a write is not counted and raises no request.
- R7: While enable is 0, no strobe raises the request, and the counter stops at its maximum value instead of wrapping.
- R8: With `HAS_SIGNAL`=0, `irq_pulse` never goes high.
- R9: With `HAS_THRESH`=0 and enable set, every accepted strobe raises the request.
- R10: After reset the control word reads 0, so signalling is off, and `irq_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data for the control word |
| reg_rdata | output | 32 | Current control word as read back |
| err_strobe | input | 1 | One pulse for each corrected error |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The counter is never visible at the ports. A wrong count shows up only when a request appears early, late or not at all, one cycle after the strobe that should reach the threshold. A stored field that is corrupted or wrongly masked appears on `reg_rdata` in the cycle right after the write. The bench therefore compares the readback and the request every cycle against a model, for a full build and for each reduced build. A counter that does not saturate stays hidden until the next enable, because the write that sets the enable clears the counter. An assertion inside the counter catches that fault.

// File: rtl/cet_pkg.sv
package cet_pkg;
  // Action taken by the error counter in one cycle
  typedef enum logic [2:0] {
    CNT_HOLD,
    CNT_CLEAR,
    CNT_INC,
    CNT_SAT,
    CNT_FIRE
  } cnt_act_e;
endpackage

// File: rtl/cet_ctl_reg.sv
module cet_ctl_reg #(
  parameter int WORD_W     = 32,
  parameter int THR_W      = 15,
  parameter int EN_POS     = 30,
  parameter bit HAS_THRESH = 1'b1,
  parameter bit HAS_SIGNAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [THR_W-1:0]  thr,
  output logic              en,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [WORD_W-1:0] THR_MASK = WORD_W'((1 << THR_W) - 1);
  localparam logic [WORD_W-1:0] EN_MASK  = WORD_W'(1) << EN_POS;
  localparam logic [WORD_W-1:0] LIVE_MASK =
    (HAS_THRESH ? THR_MASK : '0) | (HAS_SIGNAL ? EN_MASK : '0);

  generate
    if (HAS_THRESH) begin : g_thr
      logic [THR_W-1:0] thr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  thr_q <= '0;
        else if (wr) thr_q <= wdata[THR_W-1:0];
      end
      assign thr = thr_q;
    end else begin : g_no_thr
      assign thr = '0;
    end

    if (HAS_SIGNAL) begin : g_sig
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  en_q <= 1'b0;
        else if (wr) en_q <= wdata[EN_POS];
      end
      assign en = en_q;
    end else begin : g_no_sig
      assign en = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    rdata[THR_W-1:0] = thr;
    rdata[EN_POS]    = en;
  end

  // R3: bits outside the implemented fields never read as one
  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~LIVE_MASK) == '0);

  // R1: the word changes only on a write
  assert_word_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(rdata));
endmodule

// File: rtl/cet_err_counter.sv
module cet_err_counter
  import cet_pkg::*;
#(
  parameter int THR_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             strobe,
  input  logic             en,
  input  logic [THR_W-1:0] thr,
  output logic             fire_q,
  output cnt_act_e         act
);
  localparam logic [THR_W-1:0] CNT_MAX = '1;

  logic [THR_W-1:0] cnt;

  // Threshold that actually applies: zero counts as one
  function automatic logic [THR_W-1:0] eff_thr(input logic [THR_W-1:0] t);
    return (t == '0) ? THR_W'(1) : t;
  endfunction

  // True when one more error reaches the threshold
  function automatic logic reaches(input logic [THR_W-1:0] c,
                                   input logic [THR_W-1:0] t);
    return ({1'b0, c} + 1'b1) >= {1'b0, eff_thr(t)};
  endfunction

  always_comb begin
    act = CNT_HOLD;
    if (clr)                act = CNT_CLEAR;
    else if (strobe && en)  act = reaches(cnt, thr) ? CNT_FIRE : CNT_INC;
    else if (strobe)        act = (cnt == CNT_MAX) ? CNT_SAT : CNT_INC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= (act == CNT_FIRE);
      case (act)
        CNT_CLEAR, CNT_FIRE: cnt <= '0;
        CNT_INC:             cnt <= cnt + 1'b1;
        default:             cnt <= cnt;
      endcase
    end
  end

  // R4: with signalling on, the count stays below the threshold
  assert_cnt_below_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < eff_thr(thr)));

  // R4: a request follows only an accepted strobe while enabled
  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> $past(strobe && en && !clr));

  // R5: a zero threshold fires on every accepted strobe
  assert_zero_thr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && thr == '0 && strobe && !clr) |=> fire_q);

  // R6: a write leaves the counter at zero and raises nothing
  assert_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !fire_q));

  // R7: the counter stops at its maximum while disabled
  assert_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/cet_bank.sv
module cet_bank
  import cet_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int THR_W      = 15,
  parameter int EN_POS     = 30,
  parameter bit HAS_THRESH = 1'b1,
  parameter bit HAS_SIGNAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              err_strobe,
  output logic              irq_pulse
);
  logic [THR_W-1:0] thr_w;
  logic             en_w;
  logic             fire_w;
  cnt_act_e         act_w;

  cet_ctl_reg #(
    .WORD_W(WORD_W), .THR_W(THR_W), .EN_POS(EN_POS),
    .HAS_THRESH(HAS_THRESH), .HAS_SIGNAL(HAS_SIGNAL)
  ) ctl_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .thr(thr_w), .en(en_w), .rdata(reg_rdata)
  );

  cet_err_counter #(.THR_W(THR_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(reg_wr), .strobe(err_strobe),
    .en(en_w), .thr(thr_w), .fire_q(fire_w), .act(act_w)
  );

  assign irq_pulse = fire_w;

  // R4: a request lasts exactly one cycle unless another strobe fires again
  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && !(err_strobe && en_w && !reg_wr)) |=> !irq_pulse);

  generate
    if (!HAS_SIGNAL) begin : g_nosig_chk
      // R8: a bank without signalling never requests
      assert_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pulse);
    end
  endgenerate
endmodule

// File: tb/cet_bank_tb.sv
module cet_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        err_strobe = 1'b0;
  logic [31:0] rd [3];
  logic        irq [3];

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state per instance: 0 full, 1 no threshold, 2 no signalling
  bit          has_t [3] = '{1'b1, 1'b0, 1'b1};
  bit          has_s [3] = '{1'b1, 1'b1, 1'b0};
  logic [14:0] m_thr [3];
  logic        m_en  [3];
  logic [14:0] m_cnt [3];
  logic        m_fire [3];

  always #2 clk = ~clk;

  cet_bank dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd[0]), .err_strobe(err_strobe), .irq_pulse(irq[0]));
  cet_bank #(.HAS_THRESH(1'b0)) dut_nothr_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd[1]), .err_strobe(err_strobe), .irq_pulse(irq[1]));
  cet_bank #(.HAS_SIGNAL(1'b0)) dut_nosig_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd[2]), .err_strobe(err_strobe), .irq_pulse(irq[2]));

  function automatic logic [14:0] exp_eff(input logic [14:0] t);
    return t | {14'b0, ~|t};
  endfunction

  function automatic logic [31:0] exp_word(input int i);
    logic [31:0] w;
    w = 32'h0;
    w[14:0] = m_thr[i];
    w[30]   = m_en[i];
    return w;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input bit w, input logic [31:0] d, input bit s);
    for (int i = 0; i < 3; i++) begin
      m_fire[i] = 1'b0;
      if (w) begin
        m_thr[i] = has_t[i] ? d[14:0] : 15'h0;
        m_en[i]  = has_s[i] ? d[30] : 1'b0;
        m_cnt[i] = 15'h0;
      end else if (s) begin
        if (m_en[i]) begin
          if (m_cnt[i] + 15'd1 >= exp_eff(m_thr[i])) begin
            m_fire[i] = 1'b1;
            m_cnt[i]  = 15'h0;
          end else m_cnt[i] = m_cnt[i] + 15'd1;
        end else if (m_cnt[i] != 15'h7fff) m_cnt[i] = m_cnt[i] + 15'd1;
      end
    end
  endtask

  task automatic step(input bit w, input logic [31:0] d, input bit s, input string tag);
    @(negedge clk);
    reg_wr = w; reg_wdata = d; err_strobe = s;
    model_step(w, d, s);
    @(posedge clk);
    #1;
    chk(tag, "irq full", {31'b0, irq[0]}, {31'b0, m_fire[0]});
    chk("R9", "irq nothr", {31'b0, irq[1]}, {31'b0, m_fire[1]});
    chk("R8", "irq nosig", {31'b0, irq[2]}, 32'h0);
    for (int i = 0; i < 3; i++) begin
      logic [31:0] e;
      e = exp_word(i);
      chk("R1", "thr field", {17'b0, rd[i][14:0]}, {17'b0, e[14:0]});
      chk("R2", "enable bit", {31'b0, rd[i][30]}, {31'b0, e[30]});
      chk("R3", "reserved", rd[i] & 32'hBFFF8000, 32'h0);
    end
  endtask

  task automatic strobes(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 32'h0, 1'b1, tag);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_thr[i] = '0; m_en[i] = 1'b0; m_cnt[i] = '0; m_fire[i] = 1'b0;
    end
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    for (int i = 0; i < 3; i++) begin
      chk("R10", "reset word", rd[i], 32'h0);
      chk("R10", "reset irq", {31'b0, irq[i]}, 32'h0);
    end

    // R3: all ones written, only the live fields persist
    step(1'b1, 32'hFFFF_FFFF, 1'b0, "R3");
    // R4: threshold 3, third strobe fires
    step(1'b1, 32'h4000_0003, 1'b0, "R4");
    strobes(6, "R4");
    // R6: the write in the middle of a count restarts it
    strobes(2, "R6");
    step(1'b1, 32'h4000_0003, 1'b0, "R6");
    strobes(3, "R6");
    // R6: a strobe together with a write is dropped
    step(1'b1, 32'h4000_0001, 1'b1, "R6");
    strobes(2, "R6");
    // R5: zero threshold, every strobe fires
    step(1'b1, 32'h4000_0000, 1'b0, "R5");
    strobes(4, "R5");
    // R7: disabled, no request
    step(1'b1, 32'h0000_0001, 1'b0, "R7");
    strobes(10, "R7");
    // R4: the largest threshold
    step(1'b1, 32'h4000_7FFF, 1'b0, "R4");
    strobes(32768, "R4");

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      bit w;
      logic [31:0] d;
      w = ($urandom % 25) == 0;
      d = $urandom;
      if (($urandom % 4) != 0) d[14:0] = 15'($urandom % 6);
      if (($urandom % 5) != 0) d[30] = 1'b1;
      step(w, d, 1'(($urandom % 2)), "R4");
    end

    @(negedge clk);
    reg_wr = 1'b0; err_strobe = 1'b0;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule